// File: doc/BRIEF.md
# Activation Table Residency Decoder

This block sits at the instruction entry of an activation engine. It accepts one 64-byte instruction bundle per valid/ready handshake. A single register holds the index of the lookup-table set that is currently resident. A table-load bundle installs a new index in that register. An activate bundle supplies only a function code. The block pairs that code with the held index and issues a lookup request to the evaluation datapath, which sits downstream.

Neither bundle type carries both halves of the reference. The load holds no table address, and the activate holds no set id. The two meet only through the held state. After reset, that state is an all-ones value meaning "nothing resident". The block checks headers, payload padding, the set-index range and opcode legality. Any bundle that fails a check raises exactly one error pulse and has no other effect.

Byte k of a bundle occupies bits [8k+7:8k] of `in_bundle`.

Top module: `act_lut_residency`

## Requirements
- R1: After reset, `cur_set` is 0xFF (no set resident), `out_valid` is 0 and every error flag is 0.
- R2: For opcodes 0x21 and 0x23, the header must hold 0x10 in byte 1 and zero in bytes 2 and 3. If it does not, `err_hdr` pulses, and neither residency nor the output changes.
- R3: A table-load has opcode 0x23 in byte 0. When its header is good, its padding is zero and the index in byte 0x23 is below NUM_SETS (default 21), the load sets `cur_set` to that index. The new index replaces any earlier one.
- R4: A table-load with a good header fails the padding check if any byte other than 0x00–0x03 and 0x23 is nonzero. It then pulses `err_malformed` and leaves `cur_set` unchanged.
- R5: A well-formed table-load whose index is NUM_SETS or more pulses `err_range` and leaves `cur_set` unchanged.
- R6: An activate has opcode 0x21 in byte 0. When its header is good and a set is resident, it produces a request on the next cycle. The request has `out_valid`=1, `out_set` equal to `cur_set`, and `out_func` equal to byte 0x23 of the activate.
- R7: An activate with a good header that arrives while `cur_set` is 0xFF pulses `err_notable` and produces no request.
- R8: Any opcode other than 0x21 and 0x23, including the pseudo-load 0xC6, pulses `err_opcode` and leaves `cur_set` unchanged.
- R9: While `out_valid`=1 and `out_ready`=0, `out_set` and `out_func` stay stable and `in_ready` is 0.
- R10: Each error flag is a one-cycle pulse in the cycle after the offending bundle is accepted. At most one flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Bundle can be accepted |
| in_bundle | input | 512 | Instruction bundle, byte k at bits [8k+7:8k] |
| out_valid | output | 1 | Lookup request pending |
| out_ready | input | 1 | Downstream takes the request |
| out_set | output | 8 | Resident set index of the request |
| out_func | output | 8 | Function code of the request |
| cur_set | output | 8 | Resident set index, 0xFF when none |
| err_hdr | output | 1 | Bad word length or nonzero reserved bytes |
| err_opcode | output | 1 | Unknown or pseudo opcode |
| err_malformed | output | 1 | Table-load with nonzero padding |
| err_range | output | 1 | Table-load index out of range |
| err_notable | output | 1 | Activate with no set resident |

## Verification
The embedded assertions check several properties on every cycle:
- the resident index is always either the sentinel or below NUM_SETS;
- a request never carries the sentinel;
- request fields stay stable under back-pressure;
- error flags appear only after an acceptance, and never two at once;
- the pseudo-load never moves residency.

Only the directed scenarios can show that the correct index is installed or replaced, and that each kind of malformed bundle maps to its own flag. They also show that the function code and set are joined correctly, and that a queued activate is taken exactly once when back-pressure lifts.

// File: rtl/act_lut_residency.sv
module act_lut_residency #(
  parameter int NUM_SETS     = 21,
  parameter int IDX_W        = 8,
  parameter int BUNDLE_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [BUNDLE_BYTES*8-1:0] in_bundle,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [IDX_W-1:0]          out_set,
  output logic [IDX_W-1:0]          out_func,
  output logic [IDX_W-1:0]          cur_set,
  output logic                      err_hdr,
  output logic                      err_opcode,
  output logic                      err_malformed,
  output logic                      err_range,
  output logic                      err_notable
);
  localparam int BW      = BUNDLE_BYTES * 8;
  localparam int SEL_LSB = 8 * 35;
  localparam logic [7:0] OP_ACT  = 8'h21;
  localparam logic [7:0] OP_LOAD = 8'h23;
  localparam logic [7:0] WLEN    = 8'(BUNDLE_BYTES / 4);
  localparam logic [IDX_W-1:0] NONE = '1;
  localparam logic [IDX_W:0]   NSETS = (IDX_W+1)'(NUM_SETS);
  localparam logic [BW-1:0] HDR_MASK = BW'(32'hFFFF_FFFF);
  localparam logic [BW-1:0] SEL_MASK = BW'({IDX_W{1'b1}}) << SEL_LSB;

  logic [7:0]       opcode;
  logic [IDX_W-1:0] sel;
  logic acc, hdr_ok, is_load, is_act, pad_nz, in_rng;
  logic do_load, do_act;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign opcode   = in_bundle[7:0];
  assign sel      = in_bundle[SEL_LSB +: IDX_W];
  assign hdr_ok   = (in_bundle[15:8] == WLEN) && (in_bundle[31:16] == 16'h0);
  assign is_load  = (opcode == OP_LOAD);
  assign is_act   = (opcode == OP_ACT);
  assign pad_nz   = |(in_bundle & ~(HDR_MASK | SEL_MASK));
  assign in_rng   = {1'b0, sel} < NSETS;
  assign do_load  = acc && is_load && hdr_ok && !pad_nz && in_rng;
  assign do_act   = acc && is_act && hdr_ok && (cur_set != NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_set       <= NONE;
      out_valid     <= 1'b0;
      out_set       <= '0;
      out_func      <= '0;
      err_hdr       <= 1'b0;
      err_opcode    <= 1'b0;
      err_malformed <= 1'b0;
      err_range     <= 1'b0;
      err_notable   <= 1'b0;
    end else begin
      if (do_load) cur_set <= sel;
      if (do_act) begin
        out_valid <= 1'b1;
        out_set   <= cur_set;
        out_func  <= sel;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      err_hdr       <= acc && (is_load || is_act) && !hdr_ok;
      err_opcode    <= acc && !is_load && !is_act;
      err_malformed <= acc && is_load && hdr_ok && pad_nz;
      err_range     <= acc && is_load && hdr_ok && !pad_nz && !in_rng;
      err_notable   <= acc && is_act && hdr_ok && (cur_set == NONE);
    end
  end

  // R3 R5
  resident_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_set == NONE) || ({1'b0, cur_set} < NSETS));

  // R7
  no_sentinel_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_set != NONE));

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_set) && $stable(out_func)));

  // R10
  single_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_hdr, err_opcode, err_malformed, err_range, err_notable}));

  // R10
  err_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !(err_hdr || err_opcode || err_malformed || err_range || err_notable));

  // R8
  pseudo_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && opcode == 8'hC6) |=> ($stable(cur_set) && err_opcode));
endmodule

// File: tb/test_act_lut_residency.sv
module test_act_lut_residency;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [511:0] in_bundle = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_set, out_func, cur_set;
  logic err_hdr, err_opcode, err_malformed, err_range, err_notable;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  act_lut_residency i_act_lut_residency (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bundle(in_bundle), .out_valid(out_valid), .out_ready(out_ready),
    .out_set(out_set), .out_func(out_func), .cur_set(cur_set),
    .err_hdr(err_hdr), .err_opcode(err_opcode), .err_malformed(err_malformed),
    .err_range(err_range), .err_notable(err_notable));

  function automatic logic [511:0] mk(input logic [7:0] op, input logic [7:0] b23);
    logic [511:0] b = '0;
    b[7:0]     = op;
    b[15:8]    = 8'h10;
    b[287:280] = b23;
    return b;
  endfunction

  function automatic logic [4:0] errs();
    return {err_hdr, err_opcode, err_malformed, err_range, err_notable};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [511:0] b);
    @(negedge clk);
    in_valid  = 1'b1;
    in_bundle = b;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 cur_set", cur_set, 8'hFF);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 errors", errs(), 0);
  endtask

  task automatic t_no_table;
    send(mk(8'h21, 8'h07));
    chk("R7 err_notable", errs(), 5'b00001);
    chk("R7 no request", out_valid, 0);
  endtask

  task automatic t_load_and_act;
    send(mk(8'h23, 8'd5));
    chk("R3 load 5", cur_set, 8'd5);
    chk("R3 no error", errs(), 0);
    send(mk(8'h21, 8'h07));
    chk("R6 out_valid", out_valid, 1);
    chk("R6 out_set", out_set, 8'd5);
    chk("R6 out_func", out_func, 8'h07);
    @(negedge clk);
    chk("R6 request retires", out_valid, 0);
    send(mk(8'h23, 8'd20));
    chk("R3 replace with 20", cur_set, 8'd20);
    send(mk(8'h21, 8'h05));
    chk("R6 set follows latest load", out_set, 8'd20);
    chk("R6 func 05", out_func, 8'h05);
  endtask

  task automatic t_range;
    send(mk(8'h23, 8'd21));
    chk("R5 err_range 21", errs(), 5'b00010);
    chk("R5 unchanged", cur_set, 8'd20);
    send(mk(8'h23, 8'hFF));
    chk("R5 err_range FF", errs(), 5'b00010);
    chk("R5 unchanged FF", cur_set, 8'd20);
  endtask

  task automatic t_malformed;
    logic [511:0] b;
    b = mk(8'h23, 8'd3);
    b[8*40 +: 8] = 8'h01;
    send(b);
    chk("R4 err_malformed byte40", errs(), 5'b00100);
    chk("R4 unchanged", cur_set, 8'd20);
    b = mk(8'h23, 8'd3);
    b[8*34 +: 8] = 8'h80;
    send(b);
    chk("R4 err_malformed byte22", errs(), 5'b00100);
    chk("R4 unchanged 2", cur_set, 8'd20);
  endtask

  task automatic t_header;
    logic [511:0] b;
    b = mk(8'h23, 8'd3);
    b[15:8] = 8'h0F;
    send(b);
    chk("R2 err_hdr wlen", errs(), 5'b10000);
    chk("R2 load ignored", cur_set, 8'd20);
    b = mk(8'h21, 8'h06);
    b[23:16] = 8'h01;
    send(b);
    chk("R2 err_hdr reserved", errs(), 5'b10000);
    chk("R2 no request", out_valid, 0);
  endtask

  task automatic t_pseudo;
    send(mk(8'hC6, 8'd2));
    chk("R8 err_opcode C6", errs(), 5'b01000);
    chk("R8 C6 no residency change", cur_set, 8'd20);
    send(mk(8'h55, 8'd1));
    chk("R8 err_opcode 55", errs(), 5'b01000);
    chk("R8 unchanged", cur_set, 8'd20);
  endtask

  task automatic t_backpressure;
    out_ready = 1'b0;
    send(mk(8'h21, 8'h11));
    chk("R9 first request", out_func, 8'h11);
    chk("R9 in_ready low", in_ready, 0);
    in_valid  = 1'b1;
    in_bundle = mk(8'h21, 8'h22);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R9 held valid", out_valid, 1);
      chk("R9 held func", out_func, 8'h11);
      chk("R9 held set", out_set, 8'd20);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second request", out_func, 8'h22);
    chk("R9 second valid", out_valid, 1);
    @(negedge clk);
    chk("R9 accepted once", out_valid, 0);
  endtask

  task automatic t_pulse;
    send(mk(8'hC6, 8'd0));
    chk("R10 pulse present", err_opcode, 1);
    @(negedge clk);
    chk("R10 pulse cleared", errs(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_table();
    t_load_and_act();
    t_range();
    t_malformed();
    t_header();
    t_pseudo();
    t_backpressure();
    t_pulse();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule